// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block merges sixteen device interrupt lines into one interrupt request for a processor. Two identical eight-input controller units are chained. The primary unit serves lines 0 to 7. The secondary unit serves lines 8 to 15, and its combined request takes the place of primary input 2. Each unit keeps three registers: a pending register that captures rising edges, a mask register, and an in-service register. Each unit picks a winner by fixed priority, and input 0 has the highest priority.

Software reaches each unit through two byte addresses on a small I/O bus. The even address takes commands when written and returns the pending register when read. The odd address holds the mask, which can be read and written. When the processor acknowledges, the block returns an 8-bit vector number and moves the winning request into service. A later end-of-interrupt command releases the level that was in service. A device still wired to the old line 2 is redirected to secondary input 1, so it appears as line 9.

Top module: `irq_cascade_top`

## Requirements
- R1: Primary line n (0..7) acknowledges with vector 08h+n. Secondary line m (8..15) acknowledges with vector 70h+(m-8). The secondary unit's combined request drives primary input 2.
- R2: A rising edge on legacy input line 2 is handled as secondary input 1 and acknowledges with vector 71h. No device request reaches primary input 2 directly.
- R3: A mask bit of 1 blocks its input and a mask bit of 0 enables it. Both masks reset to FFh. Setting primary mask bit 2 blocks every secondary line.
- R4: The primary unit answers at 20h (command write / pending read) and 21h (mask read/write). The secondary unit answers at A0h and A1h. Reads from any other address return 00h.
- R5: A request is captured on a rising edge after a two-stage synchronizer, so it is pending three clock edges after the line rises. A line held high produces exactly one request.
- R6: Among pending, unmasked requests in one unit, the lowest-numbered input wins.
- R7: An acknowledge while `cpu_int` is high returns the winner's vector, clears its pending bit and sets its in-service bit.
- R8: A pending request whose priority is equal to or lower than an in-service level is not presented until that level is ended.
- R9: While primary input 2 is in service, a secondary request that outranks the secondary unit's own in-service level is still presented.
- R10: Writing 20h to a unit's command address clears that unit's highest-priority in-service bit. Any other command value has no effect.
- R11: An acknowledge while `cpu_int` is low returns vector 0Fh and changes no state.
- R12: After reset, `cpu_int` is low and both pending and in-service registers are empty. `cpu_int` is high exactly when the primary unit has a request to present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | Device request lines 0..15 (line 2 is the legacy input) |
| io_addr | input | 8 | I/O bus address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (zero when not selected) |
| cpu_int | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle interrupt acknowledge |
| ack_vector | output | 8 | Vector number, valid during `int_ack` |

## Verification
The bench builds the block with its default parameters: units at 20h and A0h, vector bases 08h and 70h, the cascade on primary input 2, the legacy redirect to secondary input 1, and two synchronizer stages. These values allow checking the exact three-edge capture latency, every vector number against its fixed base, and the interaction between the cascade input's relaxed nesting and the secondary unit's own nesting. Table rows sweep single lines, simultaneous lines and mask patterns from reset. Directed sequences then stack in-service levels and release them one command at a time.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int  UNIT_LINES = 8;
   localparam int  BUS_W      = 8;
   typedef logic [BUS_W-1:0] bus_t;
   localparam bus_t CMD_EOI   = 8'h20;
   localparam bus_t MASK_RST  = 8'hFF;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int         N          = 8,
   parameter int         STAGES     = 2,
   parameter logic [7:0] LEVEL_MASK = 8'h00
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] req
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_edge_capture: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (LEVEL_MASK[i]) begin : g_level
         // internal cascade signal: already synchronous, passed as a level
         assign req[i] = raw[i];
      end else begin : g_edge
         logic [STAGES:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-1:0], raw[i]};
         end
         assign req[i] = sh[STAGES-1] & ~sh[STAGES];
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int         N    = 8,
   parameter int         IW   = (N > 1) ? $clog2(N) : 1,
   parameter logic [7:0] CASC = 8'h00
) (
   input  logic [N-1:0]  elig,
   input  logic [N-1:0]  isr,
   output logic          present,
   output logic [IW-1:0] win,
   output logic          isr_any,
   output logic [IW-1:0] isr_top
);
   always_comb begin
      isr_any = 1'b0;
      isr_top = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (isr[i]) begin
            isr_any = 1'b1;
            isr_top = IW'(i);
         end
      end
   end

   always_comb begin
      present = 1'b0;
      win     = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i] && (!isr_any || (i < int'(isr_top)) ||
                         ((i == int'(isr_top)) && CASC[i]))) begin
            present = 1'b1;
            win     = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
   import irq_pkg::*;
#(
   parameter int         N          = 8,
   parameter int         IW         = (N > 1) ? $clog2(N) : 1,
   parameter logic [7:0] BASE_ADDR  = 8'h20,
   parameter logic [7:0] VEC_BASE   = 8'h08,
   parameter logic [7:0] LEVEL_MASK = 8'h00,
   parameter int         STAGES     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  lines,
   input  bus_t          addr,
   input  logic          rd,
   input  logic          wr,
   input  bus_t          wdata,
   output bus_t          rdata,
   input  logic          ack,
   output logic          int_o,
   output logic [IW-1:0] win,
   output bus_t          vec,
   output logic [N-1:0]  isr_o
);
   localparam logic [N-1:0] LEV = LEVEL_MASK[N-1:0];

   if (N < 1 || N > UNIT_LINES) begin : g_bad_n
      $error("irq_unit: N out of range");
   end
   if (BASE_ADDR[0] != 1'b0) begin : g_bad_addr
      $error("irq_unit: BASE_ADDR must be even");
   end

   logic [N-1:0] req, irr_q, irr, imr_q, isr_q, clr;
   logic         present, isr_any, hit, eoi, mask_wr;
   logic [IW-1:0] isr_top;

   irq_edge_capture #(.N(N), .STAGES(STAGES), .LEVEL_MASK(LEVEL_MASK)) u_cap (
      .clk(clk), .rst_n(rst_n), .raw(lines), .req(req)
   );

   assign irr = (irr_q & ~LEV) | (req & LEV);

   irq_prio_pick #(.N(N), .IW(IW), .CASC(LEVEL_MASK)) u_pick (
      .elig(irr & ~imr_q), .isr(isr_q), .present(present), .win(win),
      .isr_any(isr_any), .isr_top(isr_top)
   );

   assign hit     = (addr[7:1] == BASE_ADDR[7:1]);
   assign eoi     = wr && hit && !addr[0] && (wdata == CMD_EOI);
   assign mask_wr = wr && hit && addr[0];
   assign clr     = (ack && present) ? (N'(1) << win) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q <= '0;
         imr_q <= MASK_RST[N-1:0];
         isr_q <= '0;
      end else begin
         irr_q <= ((irr_q & ~clr) | req) & ~LEV;
         if (mask_wr) imr_q <= wdata[N-1:0];
         isr_q <= (isr_q & ~((eoi && isr_any) ? (N'(1) << isr_top) : '0)) | clr;
      end
   end

   assign int_o = present;
   assign vec   = VEC_BASE + 8'(win);
   assign isr_o = isr_q;
   assign rdata = (hit && rd) ? (addr[0] ? 8'(imr_q) : 8'(irr)) : '0;

   a_r3_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
      present |-> !imr_q[win]);
   a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && present) |=> isr_q[$past(win)]);
   a_r10_eoi_releases_top: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && isr_any && !(ack && present)) |=> !isr_q[$past(isr_top)]);
   a_r7_one_level_per_ack: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(isr_q) <= $countones($past(isr_q)) + 1));
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
   import irq_pkg::*;
#(
   parameter logic [7:0] PRI_ADDR     = 8'h20,
   parameter logic [7:0] SEC_ADDR     = 8'hA0,
   parameter logic [7:0] PRI_VEC      = 8'h08,
   parameter logic [7:0] SEC_VEC      = 8'h70,
   parameter int         CASC_LINE    = 2,
   parameter int         LEGACY_SLOT  = 1,
   parameter int         SYNC_STAGES  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [15:0] irq_lines,
   input  logic [7:0]  io_addr,
   input  logic        io_rd,
   input  logic        io_wr,
   input  logic [7:0]  io_wdata,
   output logic [7:0]  io_rdata,
   output logic        cpu_int,
   input  logic        int_ack,
   output logic [7:0]  ack_vector
);
   localparam int         N        = UNIT_LINES;
   localparam int         IW       = $clog2(N);
   localparam logic [7:0] CASC_BIT = 8'(1) << CASC_LINE;
   localparam logic [7:0] LEG_BIT  = 8'(1) << LEGACY_SLOT;

   if (CASC_LINE < 0 || CASC_LINE >= N || LEGACY_SLOT < 0 || LEGACY_SLOT >= N) begin : g_bad_line
      $error("irq_cascade_top: cascade or legacy slot out of range");
   end
   if (PRI_ADDR[7:1] == SEC_ADDR[7:1]) begin : g_bad_map
      $error("irq_cascade_top: unit address ranges overlap");
   end

   logic [N-1:0]  p_lines, s_lines, p_isr, s_isr;
   logic          p_int, s_int, p_ack, s_ack;
   logic [IW-1:0] p_win, s_win;
   bus_t          p_vec, s_vec, p_rdata, s_rdata;

   // legacy line redirect onto the secondary unit; cascade output onto primary
   assign s_lines = irq_lines[15:8] | (irq_lines[CASC_LINE] ? LEG_BIT : 8'h00);
   assign p_lines = (irq_lines[7:0] & ~CASC_BIT) | (s_int ? CASC_BIT : 8'h00);

   assign p_ack = int_ack && p_int;
   assign s_ack = p_ack && (p_win == IW'(CASC_LINE));

   irq_unit #(.N(N), .IW(IW), .BASE_ADDR(PRI_ADDR), .VEC_BASE(PRI_VEC),
              .LEVEL_MASK(CASC_BIT), .STAGES(SYNC_STAGES)) u_pri (
      .clk(clk), .rst_n(rst_n), .lines(p_lines), .addr(io_addr), .rd(io_rd),
      .wr(io_wr), .wdata(io_wdata), .rdata(p_rdata), .ack(p_ack), .int_o(p_int),
      .win(p_win), .vec(p_vec), .isr_o(p_isr)
   );

   irq_unit #(.N(N), .IW(IW), .BASE_ADDR(SEC_ADDR), .VEC_BASE(SEC_VEC),
              .LEVEL_MASK(8'h00), .STAGES(SYNC_STAGES)) u_sec (
      .clk(clk), .rst_n(rst_n), .lines(s_lines), .addr(io_addr), .rd(io_rd),
      .wr(io_wr), .wdata(io_wdata), .rdata(s_rdata), .ack(s_ack), .int_o(s_int),
      .win(s_win), .vec(s_vec), .isr_o(s_isr)
   );

   assign cpu_int    = p_int;
   assign io_rdata   = p_rdata | s_rdata;
   assign ack_vector = !p_int ? (PRI_VEC + 8'(N - 1)) :
                       (p_win == IW'(CASC_LINE)) ? s_vec : p_vec;

   a_r11_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && !cpu_int) |=> (p_isr == $past(p_isr)) && (s_isr == $past(s_isr)));
   a_r1_cascade_ack_pairs: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && cpu_int && (p_win == IW'(CASC_LINE))) |-> s_int);
   a_r1_secondary_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && cpu_int && (p_win == IW'(CASC_LINE))) |-> (ack_vector[7:3] == SEC_VEC[7:3]));
endmodule

// File: tb/tb_irq_cascade_top.sv
module tb_irq_cascade_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_lines = '0;
   logic [7:0]  io_addr = '0, io_wdata = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0, int_ack = 1'b0;
   logic [7:0]  io_rdata, ack_vector;
   logic        cpu_int;

   int checks = 0, fails = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   irq_cascade_top dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .io_addr(io_addr),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .cpu_int(cpu_int), .int_ack(int_ack), .ack_vector(ack_vector)
   );

   typedef struct packed {
      logic [15:0] lines;
      logic [7:0]  pmask;
      logic [7:0]  smask;
      logic        eint;
      logic [7:0]  evec;
   } row_t;

   localparam row_t TBL [10] = '{
      '{16'h0001, 8'h00, 8'hFF, 1'b1, 8'h08},  // R1 line 0
      '{16'h0020, 8'h00, 8'hFF, 1'b1, 8'h0D},  // R1 line 5
      '{16'h1000, 8'h00, 8'h00, 1'b1, 8'h74},  // R1 line 12
      '{16'h0004, 8'h00, 8'h00, 1'b1, 8'h71},  // R2 legacy line 2
      '{16'h000A, 8'h00, 8'hFF, 1'b1, 8'h09},  // R6 lines 1 and 3
      '{16'h8000, 8'h00, 8'h00, 1'b1, 8'h77},  // R1 line 15
      '{16'h0101, 8'h00, 8'h00, 1'b1, 8'h08},  // R6 lines 0 and 8
      '{16'h0010, 8'h10, 8'hFF, 1'b0, 8'h00},  // R3 masked line 4
      '{16'h2000, 8'h04, 8'h00, 1'b0, 8'h00},  // R3 cascade bit masked
      '{16'h0080, 8'h00, 8'hFF, 1'b1, 8'h0F}   // R1 line 7
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_lines = '0; int_ack = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] l);
      @(negedge clk);
      irq_lines = irq_lines | l;
      repeat (3) @(posedge clk);
      @(negedge clk);
      irq_lines = irq_lines & ~l;
   endtask

   task automatic do_ack(output logic [7:0] v);
      @(negedge clk);
      int_ack = 1'b1;
      #1 v = ack_vector;
      @(negedge clk);
      int_ack = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v, d;
      do_reset();

      // R12 reset state, R4/R3 reset register values
      @(negedge clk);
      chk("R12 cpu_int after reset", 16'(cpu_int), 16'h0);
      bus_rd(8'h21, d); chk("R3 primary mask reset", 16'(d), 16'h00FF);
      bus_rd(8'hA1, d); chk("R3 secondary mask reset", 16'(d), 16'h00FF);
      bus_rd(8'h20, d); chk("R12 primary pending reset", 16'(d), 16'h0);
      bus_rd(8'hA0, d); chk("R12 secondary pending reset", 16'(d), 16'h0);

      // table walk
      for (int k = 0; k < 10; k++) begin
         do_reset();
         bus_wr(8'h21, TBL[k].pmask);
         bus_wr(8'hA1, TBL[k].smask);
         pulse(TBL[k].lines);
         chk($sformatf("R1/R3/R6 row %0d cpu_int", k), 16'(cpu_int), 16'(TBL[k].eint));
         if (TBL[k].eint) begin
            do_ack(v);
            chk($sformatf("R1/R2/R6 row %0d vector", k), 16'(v), 16'(TBL[k].evec));
         end
      end

      // R4 separate mask registers, unmapped address
      do_reset();
      bus_wr(8'h21, 8'h5A);
      bus_rd(8'h21, d); chk("R4 primary mask readback", 16'(d), 16'h005A);
      bus_rd(8'hA1, d); chk("R4 secondary mask untouched", 16'(d), 16'h00FF);
      bus_wr(8'hA1, 8'h3C);
      bus_rd(8'hA1, d); chk("R4 secondary mask readback", 16'(d), 16'h003C);
      bus_rd(8'h22, d); chk("R4 unmapped read", 16'(d), 16'h0);

      // R4/R3/R7 pending read while masked, then unmask and acknowledge
      bus_wr(8'h21, 8'h40);
      pulse(16'h0040);
      bus_rd(8'h20, d); chk("R4 pending read shows line 6", 16'(d), 16'h0040);
      chk("R3 masked line gives no int", 16'(cpu_int), 16'h0);
      bus_wr(8'h21, 8'h00);
      chk("R3 unmask presents request", 16'(cpu_int), 16'h1);
      do_ack(v); chk("R7 vector line 6", 16'(v), 16'h000E);
      bus_rd(8'h20, d); chk("R7 pending cleared by ack", 16'(d), 16'h0);

      // R8 / R10 nesting on the primary unit
      do_reset();
      bus_wr(8'h21, 8'h00);
      pulse(16'h0008);
      do_ack(v); chk("R7 vector line 3", 16'(v), 16'h000B);
      pulse(16'h0020);
      chk("R8 lower request held", 16'(cpu_int), 16'h0);
      pulse(16'h0008);
      chk("R8 equal request held", 16'(cpu_int), 16'h0);
      pulse(16'h0002);
      chk("R8 higher request presented", 16'(cpu_int), 16'h1);
      do_ack(v); chk("R6 nested vector line 1", 16'(v), 16'h0009);
      bus_wr(8'h20, 8'h00);
      chk("R10 non-EOI command ignored", 16'(cpu_int), 16'h0);
      bus_wr(8'h20, 8'h20);
      chk("R10 EOI leaves line 3 in service", 16'(cpu_int), 16'h0);
      bus_wr(8'h20, 8'h20);
      chk("R10 second EOI releases", 16'(cpu_int), 16'h1);
      do_ack(v); chk("R6 line 3 before line 5", 16'(v), 16'h000B);
      bus_wr(8'h20, 8'h20);
      do_ack(v); chk("R8 held line 5 served last", 16'(v), 16'h000D);

      // R5 edge capture: line held high gives one request
      do_reset();
      bus_wr(8'h21, 8'h00);
      @(negedge clk); irq_lines = 16'h0010;
      @(posedge clk); @(posedge clk);
      @(negedge clk); chk("R5 not yet pending after two edges", 16'(cpu_int), 16'h0);
      @(negedge clk); chk("R5 pending after three edges", 16'(cpu_int), 16'h1);
      do_ack(v); chk("R5 vector line 4", 16'(v), 16'h000C);
      bus_wr(8'h20, 8'h20);
      repeat (5) @(negedge clk);
      chk("R5 held high line no second request", 16'(cpu_int), 16'h0);
      irq_lines = 16'h0000;
      pulse(16'h0010);
      chk("R5 new edge requests again", 16'(cpu_int), 16'h1);

      // R9 cascade nesting
      do_reset();
      bus_wr(8'h21, 8'h00);
      bus_wr(8'hA1, 8'h00);
      pulse(16'h1000);
      do_ack(v); chk("R1 secondary line 12", 16'(v), 16'h0074);
      pulse(16'h4000);
      chk("R8 secondary lower held", 16'(cpu_int), 16'h0);
      pulse(16'h0200);
      chk("R9 higher secondary passes cascade", 16'(cpu_int), 16'h1);
      do_ack(v); chk("R9 vector line 9", 16'(v), 16'h0071);

      // R11 spurious acknowledge
      do_reset();
      bus_wr(8'h21, 8'h00);
      do_ack(v); chk("R11 spurious vector", 16'(v), 16'h000F);
      pulse(16'h0080);
      chk("R11 no in-service left behind", 16'(cpu_int), 16'h1);
      do_ack(v); chk("R11 real line 7 after spurious", 16'(v), 16'h000F);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule